// File: doc/BRIEF.md
# I2C Controller Interrupt Status Collector

This block gathers the event and condition signals produced by an I2C controller and turns them into a 15-source interrupt status word. The host reads the word through a register interface. Most sources latch on a one-cycle event pulse and are cleared by a strobe that stands for a read of the matching clear register. Two sources are live levels: the receive-threshold compare and the transmit-empty condition. A few sources are also cleared by the controller enable, and in some cases only once both bus state machines are idle.

A mask register with one bit per source is ANDed with the raw word to give the masked word. The OR of the masked word is registered and driven as a single interrupt line. The status outputs are 32 bits wide, and bits 31:15 always read as zero. Every pin is a plain control or status signal. No data stream passes through the block, so no valid/ready handshake is needed.

Top module: `i2c_irq_status`

## Requirements
- R1: After reset, every status bit reads 0, the interrupt line is 0, and all 15 mask bits are 1, so the first event shows up unmasked.
- R2: A latched source goes to 1 on the clock edge after its event pulse and stays at 1 until its own clear strobe arrives. Its status bit then reads 0 after that edge. Bit positions: rx_under=0, rx_over=1, rx_full=2, tx_over=3, tx_empty=4, rd_req=5, tx_abrt=6, rx_done=7, activity=8, stop_det=9, start_det=10, gen_call=11, restart_det=12, master_on_hold=13, scl_stuck_low=14. The clear strobe vector uses the same positions.
- R3: When a set event and any clear for a latched bit occur in the same cycle, the bit is 1 afterwards.
- R4: The combined clear strobe clears every latched bit in one edge. It leaves bit 2 (rx_full) and bit 4 (tx_empty) unchanged.
- R5: Bit 2 is not latched. It is 1 in the same cycle that the receive level is greater than or equal to the threshold, including the equal case, and 0 as soon as the level is below the threshold. Bit 4 follows the transmit-empty input directly. Clear strobes on bits 2 and 4 have no effect.
- R6: While ctrl_en is 0, bit 2 is 0 in that same cycle, whatever the receive level is.
- R7: After ctrl_en falls, bits 0 and 3 hold their value while either state machine is busy. They clear on the edge where ctrl_en is 0 and both mst_idle and slv_idle are 1.
- R8: Bit 11 sets on an acknowledged general-call event. It clears on its strobe, or on any edge where ctrl_en is 0.
- R9: A start or a restart event sets bit 10, and a stop event sets bit 9, in either slave or master mode.
- R10: Bit 12 sets on a restart event only when slave_mode and addressed are both 1.
- R11: masked_stat equals raw_stat ANDed with the mask. mask_we loads mask_wdata on the edge.
- R12: irq is the OR of masked_stat one clock earlier.
- R13: Bits 31:15 of raw_stat and masked_stat always read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_en | input | 1 | Controller enable |
| mst_idle | input | 1 | Master state machine idle |
| slv_idle | input | 1 | Slave state machine idle |
| slave_mode | input | 1 | Controller is operating as a slave |
| addressed | input | 1 | This slave was addressed |
| ev_rx_under | input | 1 | Read of empty receive FIFO (pulse) |
| ev_rx_over | input | 1 | Byte received into full FIFO (pulse) |
| ev_tx_over | input | 1 | Write to full transmit FIFO (pulse) |
| ev_rd_req | input | 1 | Remote master read request (pulse) |
| ev_tx_abrt | input | 1 | Transmit abort (pulse) |
| ev_rx_done | input | 1 | Slave transmit finished with NACK (pulse) |
| ev_activity | input | 1 | Bus activity seen (pulse) |
| ev_stop | input | 1 | Stop condition (pulse) |
| ev_start | input | 1 | Start condition (pulse) |
| ev_restart | input | 1 | Repeated start condition (pulse) |
| ev_gen_call | input | 1 | General call received and acknowledged (pulse) |
| ev_mst_hold | input | 1 | Master holding bus with empty transmit FIFO (pulse) |
| ev_scl_low | input | 1 | Clock line stuck low (pulse) |
| tx_empty_lvl | input | 1 | Transmit-empty condition (level) |
| rx_level | input | LVL_W | Receive FIFO fill level |
| rx_thresh | input | LVL_W | Receive threshold |
| clr_strobe | input | 15 | Per-source clear strobes |
| clr_all | input | 1 | Combined clear strobe |
| mask_we | input | 1 | Mask write enable |
| mask_wdata | input | 15 | Mask write data |
| raw_stat | output | 32 | Raw status word |
| masked_stat | output | 32 | Masked status word |
| irq | output | 1 | Registered interrupt line |

## Verification
The assertions check on every cycle that the reserved bits are zero, that the masked word never holds a bit the raw word lacks, that irq follows the OR of the masked word one edge later, and that rx_full is low while disabled. They also check that rx_over and rx_under hold without a clear, that a set event always leaves its bit high, and that restart_det cannot rise outside the addressed-slave case. Some behaviour can only be shown by the bench's scenarios, which compare against a cycle model: the idle-gated release after disable, the threshold boundary at equality, the combined clear leaving the level bits alone, and mask rewrites.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;
  localparam int unsigned NSRC   = 15;
  localparam int unsigned STAT_W = 32;

  localparam int IX_RX_UNDER  = 0;
  localparam int IX_RX_OVER   = 1;
  localparam int IX_RX_FULL   = 2;
  localparam int IX_TX_OVER   = 3;
  localparam int IX_TX_EMPTY  = 4;
  localparam int IX_RD_REQ    = 5;
  localparam int IX_TX_ABRT   = 6;
  localparam int IX_RX_DONE   = 7;
  localparam int IX_ACTIVITY  = 8;
  localparam int IX_STOP      = 9;
  localparam int IX_START     = 10;
  localparam int IX_GEN_CALL  = 11;
  localparam int IX_RESTART   = 12;
  localparam int IX_MST_HOLD  = 13;
  localparam int IX_SCL_LOW   = 14;

  // How each source bit is kept and released
  typedef enum logic [1:0] {
    CLS_PLAIN   = 2'd0,  // latched, strobe clear only
    CLS_LEVEL   = 2'd1,  // live level, never latched
    CLS_DISIDLE = 2'd2,  // latched, also cleared when disabled and idle
    CLS_DISCLR  = 2'd3   // latched, also cleared when disabled
  } bit_class_e;

  function automatic bit_class_e class_of(input int idx);
    case (idx)
      IX_RX_FULL, IX_TX_EMPTY: class_of = CLS_LEVEL;
      IX_RX_UNDER, IX_TX_OVER: class_of = CLS_DISIDLE;
      IX_GEN_CALL:             class_of = CLS_DISCLR;
      default:                 class_of = CLS_PLAIN;
    endcase
  endfunction
endpackage

// File: rtl/irq_event_map.sv
module irq_event_map
  import i2c_irq_pkg::*;
(
  input  logic            ctrl_en,
  input  logic            mst_idle,
  input  logic            slv_idle,
  input  logic            slave_mode,
  input  logic            addressed,
  input  logic            ev_rx_under,
  input  logic            ev_rx_over,
  input  logic            ev_tx_over,
  input  logic            ev_rd_req,
  input  logic            ev_tx_abrt,
  input  logic            ev_rx_done,
  input  logic            ev_activity,
  input  logic            ev_stop,
  input  logic            ev_start,
  input  logic            ev_restart,
  input  logic            ev_gen_call,
  input  logic            ev_mst_hold,
  input  logic            ev_scl_low,
  output logic [NSRC-1:0] set_vec,
  output logic [NSRC-1:0] dis_clr_vec
);
  logic release_idle;
  logic release_dis;

  assign release_idle = ~ctrl_en & mst_idle & slv_idle;
  assign release_dis  = ~ctrl_en;

  always_comb begin
    set_vec               = '0;
    set_vec[IX_RX_UNDER]  = ev_rx_under;
    set_vec[IX_RX_OVER]   = ev_rx_over;
    set_vec[IX_TX_OVER]   = ev_tx_over;
    set_vec[IX_RD_REQ]    = ev_rd_req;
    set_vec[IX_TX_ABRT]   = ev_tx_abrt;
    set_vec[IX_RX_DONE]   = ev_rx_done;
    set_vec[IX_ACTIVITY]  = ev_activity;
    set_vec[IX_STOP]      = ev_stop;
    set_vec[IX_START]     = ev_start | ev_restart;
    set_vec[IX_GEN_CALL]  = ev_gen_call;
    set_vec[IX_RESTART]   = ev_restart & slave_mode & addressed;
    set_vec[IX_MST_HOLD]  = ev_mst_hold;
    set_vec[IX_SCL_LOW]   = ev_scl_low;
  end

  always_comb begin
    for (int i = 0; i < NSRC; i++) begin
      case (class_of(i))
        CLS_DISIDLE: dis_clr_vec[i] = release_idle;
        CLS_DISCLR:  dis_clr_vec[i] = release_dis;
        default:     dis_clr_vec[i] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/irq_latch_bit.sv
module irq_latch_bit
  import i2c_irq_pkg::*;
#(
  parameter bit_class_e CLS = CLS_PLAIN
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic clr_all_i,
  input  logic dis_clr_i,
  output logic q_o
);
  logic any_clr;

  generate
    if (CLS == CLS_PLAIN) begin : g_plain
      logic unused_dis;
      assign unused_dis = dis_clr_i;
      assign any_clr = clr_i | clr_all_i;
    end else begin : g_dis
      assign any_clr = clr_i | clr_all_i | dis_clr_i;
    end
  endgenerate

  // set beats clear so a coincident event is never lost
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q_o <= 1'b0;
    else if (set_i)   q_o <= 1'b1;
    else if (any_clr) q_o <= 1'b0;
  end
endmodule

// File: rtl/irq_level_src.sv
module irq_level_src #(
  parameter int unsigned LVL_W = 6
) (
  input  logic             ctrl_en,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] rx_thresh,
  input  logic             tx_empty_lvl,
  output logic             rx_full_o,
  output logic             tx_empty_o
);
  // disabled FIFO counts as flushed: compare is masked off at once
  assign rx_full_o  = ctrl_en & (rx_level >= rx_thresh);
  assign tx_empty_o = tx_empty_lvl;
endmodule

// File: rtl/irq_out_stage.sv
module irq_out_stage
  import i2c_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   raw_i,
  input  logic              mask_we,
  input  logic [NSRC-1:0]   mask_wdata,
  output logic [STAT_W-1:0] raw_stat,
  output logic [STAT_W-1:0] masked_stat,
  output logic              irq
);
  localparam int unsigned RSV_W = STAT_W - NSRC;

  logic [NSRC-1:0] mask_q;
  logic [NSRC-1:0] masked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '1;
    else if (mask_we) mask_q <= mask_wdata;
  end

  assign masked = raw_i & mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= |masked;
  end

  assign raw_stat    = {{RSV_W{1'b0}}, raw_i};
  assign masked_stat = {{RSV_W{1'b0}}, masked};
endmodule

// File: rtl/i2c_irq_status.sv
module i2c_irq_status
  import i2c_irq_pkg::*;
#(
  parameter int unsigned LVL_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_en,
  input  logic              mst_idle,
  input  logic              slv_idle,
  input  logic              slave_mode,
  input  logic              addressed,
  input  logic              ev_rx_under,
  input  logic              ev_rx_over,
  input  logic              ev_tx_over,
  input  logic              ev_rd_req,
  input  logic              ev_tx_abrt,
  input  logic              ev_rx_done,
  input  logic              ev_activity,
  input  logic              ev_stop,
  input  logic              ev_start,
  input  logic              ev_restart,
  input  logic              ev_gen_call,
  input  logic              ev_mst_hold,
  input  logic              ev_scl_low,
  input  logic              tx_empty_lvl,
  input  logic [LVL_W-1:0]  rx_level,
  input  logic [LVL_W-1:0]  rx_thresh,
  input  logic [14:0]       clr_strobe,
  input  logic              clr_all,
  input  logic              mask_we,
  input  logic [14:0]       mask_wdata,
  output logic [31:0]       raw_stat,
  output logic [31:0]       masked_stat,
  output logic              irq
);
  logic [NSRC-1:0] set_vec;
  logic [NSRC-1:0] dis_clr_vec;
  logic [NSRC-1:0] raw;
  logic            rx_full_w;
  logic            tx_empty_w;

  irq_event_map u_map (
    .ctrl_en     (ctrl_en),
    .mst_idle    (mst_idle),
    .slv_idle    (slv_idle),
    .slave_mode  (slave_mode),
    .addressed   (addressed),
    .ev_rx_under (ev_rx_under),
    .ev_rx_over  (ev_rx_over),
    .ev_tx_over  (ev_tx_over),
    .ev_rd_req   (ev_rd_req),
    .ev_tx_abrt  (ev_tx_abrt),
    .ev_rx_done  (ev_rx_done),
    .ev_activity (ev_activity),
    .ev_stop     (ev_stop),
    .ev_start    (ev_start),
    .ev_restart  (ev_restart),
    .ev_gen_call (ev_gen_call),
    .ev_mst_hold (ev_mst_hold),
    .ev_scl_low  (ev_scl_low),
    .set_vec     (set_vec),
    .dis_clr_vec (dis_clr_vec)
  );

  irq_level_src #(.LVL_W(LVL_W)) u_lvl (
    .ctrl_en      (ctrl_en),
    .rx_level     (rx_level),
    .rx_thresh    (rx_thresh),
    .tx_empty_lvl (tx_empty_lvl),
    .rx_full_o    (rx_full_w),
    .tx_empty_o   (tx_empty_w)
  );

  generate
    for (genvar i = 0; i < NSRC; i++) begin : g_src
      if (class_of(i) == CLS_LEVEL) begin : g_level
        logic unused_lvl;
        assign unused_lvl = clr_strobe[i] ^ set_vec[i] ^ dis_clr_vec[i];
        if (i == IX_RX_FULL) begin : g_rxf
          assign raw[i] = rx_full_w;
        end else begin : g_txe
          assign raw[i] = tx_empty_w;
        end
      end else begin : g_latched
        irq_latch_bit #(.CLS(class_of(i))) u_bit (
          .clk       (clk),
          .rst_n     (rst_n),
          .set_i     (set_vec[i]),
          .clr_i     (clr_strobe[i]),
          .clr_all_i (clr_all),
          .dis_clr_i (dis_clr_vec[i]),
          .q_o       (raw[i])
        );
      end
    end
  endgenerate

  irq_out_stage u_out (
    .clk         (clk),
    .rst_n       (rst_n),
    .raw_i       (raw),
    .mask_we     (mask_we),
    .mask_wdata  (mask_wdata),
    .raw_stat    (raw_stat),
    .masked_stat (masked_stat),
    .irq         (irq)
  );
endmodule

// File: rtl/i2c_irq_status_chk.sv
module i2c_irq_status_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ctrl_en,
  input logic        mst_idle,
  input logic        slv_idle,
  input logic        slave_mode,
  input logic        addressed,
  input logic        ev_rx_over,
  input logic        ev_restart,
  input logic [14:0] clr_strobe,
  input logic        clr_all,
  input logic [31:0] raw_stat,
  input logic [31:0] masked_stat,
  input logic        irq
);
  p_reserved_zero_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_stat[31:15] == '0) && (masked_stat[31:15] == '0));

  p_masked_subset_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (masked_stat & ~raw_stat) == '0);

  p_irq_rise_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (|masked_stat) |=> irq);

  p_irq_fall_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(|masked_stat) |=> !irq);

  p_rxfull_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_en |-> !raw_stat[2]);

  p_sticky_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_stat[1] && !clr_strobe[1] && !clr_all) |=> raw_stat[1]);

  p_set_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx_over |=> raw_stat[1]);

  p_under_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_stat[0] && !clr_strobe[0] && !clr_all &&
     !(!ctrl_en && mst_idle && slv_idle)) |=> raw_stat[0]);

  p_restart_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!raw_stat[12] && !(ev_restart && slave_mode && addressed)) |=> !raw_stat[12]);
endmodule

bind i2c_irq_status i2c_irq_status_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ctrl_en     (ctrl_en),
  .mst_idle    (mst_idle),
  .slv_idle    (slv_idle),
  .slave_mode  (slave_mode),
  .addressed   (addressed),
  .ev_rx_over  (ev_rx_over),
  .ev_restart  (ev_restart),
  .clr_strobe  (clr_strobe),
  .clr_all     (clr_all),
  .raw_stat    (raw_stat),
  .masked_stat (masked_stat),
  .irq         (irq)
);

// File: tb/i2c_irq_status_tb.sv
module i2c_irq_status_tb;
  localparam int LVL_W = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctrl_en = 1'b1, mst_idle = 1'b0, slv_idle = 1'b0;
  logic slave_mode = 1'b0, addressed = 1'b0;
  logic ev_rx_under = 0, ev_rx_over = 0, ev_tx_over = 0, ev_rd_req = 0;
  logic ev_tx_abrt = 0, ev_rx_done = 0, ev_activity = 0, ev_stop = 0;
  logic ev_start = 0, ev_restart = 0, ev_gen_call = 0, ev_mst_hold = 0, ev_scl_low = 0;
  logic tx_empty_lvl = 1'b0;
  logic [LVL_W-1:0] rx_level = '0, rx_thresh = 6'd8;
  logic [14:0] clr_strobe = '0;
  logic clr_all = 1'b0, mask_we = 1'b0;
  logic [14:0] mask_wdata = '0;
  logic [31:0] raw_stat, masked_stat;
  logic irq;

  int checks = 0;
  int fails = 0;

  // bench model state
  logic [14:0] m_lat = '0;
  logic [14:0] m_mask = '1;

  logic [31:0] q_raw[$];
  logic [31:0] q_msk[$];
  logic        q_irq[$];
  string       q_req[$];
  string       cur_req = "R1";

  always #10 clk = ~clk;

  i2c_irq_status #(.LVL_W(LVL_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en), .mst_idle(mst_idle),
    .slv_idle(slv_idle), .slave_mode(slave_mode), .addressed(addressed),
    .ev_rx_under(ev_rx_under), .ev_rx_over(ev_rx_over), .ev_tx_over(ev_tx_over),
    .ev_rd_req(ev_rd_req), .ev_tx_abrt(ev_tx_abrt), .ev_rx_done(ev_rx_done),
    .ev_activity(ev_activity), .ev_stop(ev_stop), .ev_start(ev_start),
    .ev_restart(ev_restart), .ev_gen_call(ev_gen_call), .ev_mst_hold(ev_mst_hold),
    .ev_scl_low(ev_scl_low), .tx_empty_lvl(tx_empty_lvl), .rx_level(rx_level),
    .rx_thresh(rx_thresh), .clr_strobe(clr_strobe), .clr_all(clr_all),
    .mask_we(mask_we), .mask_wdata(mask_wdata), .raw_stat(raw_stat),
    .masked_stat(masked_stat), .irq(irq)
  );

  function automatic logic [14:0] lvl_bits();
    logic [14:0] v = '0;
    v[2] = ctrl_en && (rx_level >= rx_thresh);
    v[4] = tx_empty_lvl;
    return v;
  endfunction

  // driver: inputs already set (after a negedge); model the coming edge
  task automatic cyc();
    logic [14:0] s = '0;
    logic [14:0] nxt;
    logic [14:0] post;
    logic        ie;
    ie = |((m_lat | lvl_bits()) & m_mask);
    s[0] = ev_rx_under;  s[1] = ev_rx_over;  s[3] = ev_tx_over;
    s[5] = ev_rd_req;    s[6] = ev_tx_abrt;  s[7] = ev_rx_done;
    s[8] = ev_activity;  s[9] = ev_stop;     s[10] = ev_start | ev_restart;
    s[11] = ev_gen_call; s[12] = ev_restart & slave_mode & addressed;
    s[13] = ev_mst_hold; s[14] = ev_scl_low;
    for (int i = 0; i < 15; i++) begin
      logic c;
      c = clr_strobe[i] | clr_all;
      if ((i == 0 || i == 3) && !ctrl_en && mst_idle && slv_idle) c = 1'b1;
      if (i == 11 && !ctrl_en) c = 1'b1;
      if (i == 2 || i == 4) nxt[i] = 1'b0;
      else                  nxt[i] = s[i] | (m_lat[i] & ~c);
    end
    m_lat = nxt;
    if (mask_we) m_mask = mask_wdata;
    post = m_lat | lvl_bits();
    q_raw.push_back({17'b0, post});
    q_msk.push_back({17'b0, post & m_mask});
    q_irq.push_back(ie);
    q_req.push_back(cur_req);
    @(negedge clk);
    {ev_rx_under, ev_rx_over, ev_tx_over, ev_rd_req, ev_tx_abrt, ev_rx_done,
     ev_activity, ev_stop, ev_start, ev_restart, ev_gen_call, ev_mst_hold,
     ev_scl_low} = '0;
    clr_strobe = '0; clr_all = 1'b0; mask_we = 1'b0;
  endtask

  // monitor: sample 5 ns after each rising edge
  always @(posedge clk) begin
    #5;
    if (q_raw.size() > 0) begin
      logic [31:0] er, em;
      logic        ei;
      string       rq;
      er = q_raw.pop_front(); em = q_msk.pop_front();
      ei = q_irq.pop_front(); rq = q_req.pop_front();
      checks++;
      if (raw_stat !== er || masked_stat !== em || irq !== ei) begin
        fails++;
        $display("FAIL %s: raw=%h masked=%h irq=%b expected raw=%h masked=%h irq=%b",
                 rq, raw_stat, masked_stat, irq, er, em, ei);
      end
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog: run hung, actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if (raw_stat !== 32'h0 || masked_stat !== 32'h0 || irq !== 1'b0) begin
      fails++;
      $display("FAIL R1: raw=%h masked=%h irq=%b expected 0 0 0", raw_stat, masked_stat, irq);
    end
    rst_n = 1'b1;
    @(negedge clk);

    cur_req = "R1"; ev_scl_low = 1; cyc(); cyc();          // unmasked at once (mask ones)
    cur_req = "R2"; clr_strobe[14] = 1; cyc(); cyc();
    ev_rx_over = 1; cyc(); cyc(); cyc();
    clr_strobe[1] = 1; cyc(); cyc();
    ev_rd_req = 1; ev_tx_abrt = 1; ev_rx_done = 1; ev_activity = 1; ev_mst_hold = 1; cyc();
    clr_strobe[6] = 1; cyc();
    cur_req = "R3"; ev_rd_req = 1; clr_strobe[5] = 1; cyc(); cyc();
    ev_rx_over = 1; clr_all = 1; cyc(); cyc();
    cur_req = "R5"; tx_empty_lvl = 1; rx_thresh = 6'd8; rx_level = 6'd7; cyc();
    rx_level = 6'd8; cyc(); rx_level = 6'd20; cyc();
    clr_strobe[2] = 1; clr_strobe[4] = 1; cyc();
    rx_level = 6'd7; cyc(); rx_level = 6'd8; cyc();
    cur_req = "R4"; clr_all = 1; cyc(); cyc();
    cur_req = "R6"; ctrl_en = 0; rx_level = 6'd40; cyc(); cyc();
    ctrl_en = 1; cyc();
    cur_req = "R7"; ev_rx_under = 1; ev_tx_over = 1; ev_gen_call = 1; cyc();
    ctrl_en = 0; mst_idle = 0; slv_idle = 1; cyc(); cyc();
    mst_idle = 1; slv_idle = 0; cyc();
    cur_req = "R8"; ctrl_en = 1; ev_gen_call = 1; cyc(); clr_strobe[11] = 1; cyc();
    cur_req = "R7"; ctrl_en = 0; slv_idle = 1; cyc(); cyc();
    ctrl_en = 1; mst_idle = 0; slv_idle = 0; tx_empty_lvl = 0; rx_level = 0;
    cur_req = "R9"; clr_all = 1; cyc();
    ev_start = 1; cyc(); ev_stop = 1; cyc();
    clr_all = 1; cyc(); slave_mode = 1; ev_restart = 1; cyc();
    cur_req = "R10"; clr_all = 1; cyc();
    addressed = 0; ev_restart = 1; cyc(); clr_all = 1; cyc();
    addressed = 1; ev_restart = 1; cyc();
    slave_mode = 0; clr_strobe[12] = 1; clr_strobe[10] = 1; cyc();
    ev_restart = 1; cyc(); cyc();
    cur_req = "R11"; mask_we = 1; mask_wdata = 15'h0400; cyc(); cyc();
    mask_we = 1; mask_wdata = 15'h0000; cyc(); cyc();
    cur_req = "R12"; ev_activity = 1; cyc(); cyc();
    mask_we = 1; mask_wdata = 15'h0100; cyc(); cyc(); cyc();
    clr_strobe[8] = 1; cyc(); cyc();
    cur_req = "R13"; mask_we = 1; mask_wdata = 15'h7fff; tx_empty_lvl = 1;
    ev_scl_low = 1; ev_stop = 1; cyc(); cyc();
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule